// File: doc/BRIEF.md
# Table-Driven Mains Sine Reference Generator

This block synthesizes one or three amplitude-scaled sine samples locked to the supply period. It is meant to sit behind a regulator that sets current amplitude. A phase index steps once per input tick, and the tick runs at 1024 times the line frequency. The index reads a computed sine table, and each sample is multiplied by an amplitude word. The waveform shape comes only from the stored table. Harmonics or dips on the measured supply therefore cannot distort the reference; only its timing follows the line, through the tick and cycle-start inputs.

In the three-phase form every channel reads the same table at its own lag and uses the same amplitude word. The amplitude is taken in once per line cycle, at the wrap of the phase index. Within one cycle the reference amplitude therefore stays constant, even while the regulator output moves. A cycle-start pulse, taken from the positive-going zero crossing, aligns index 0 with that crossing.

Top module: `sref_gen`

## Requirements
- R1: While reset is asserted, and until the first tick after reset, every output channel reads 0. Reset also clears the phase index and the held amplitude to 0.
- R2: Table entry k holds the offset-binary code 128 + round(127·sin(2πk/1024)). A channel outputs (code − 128) × held amplitude, where the amplitude is an unsigned 8-bit value.
- R3: The phase index increases by one on each clock with `line_tick` high and wraps from 1023 to 0. Without a tick or a cycle-start it does not change.
- R4: A clock with `cyc_start` high sets the phase index to 0. This takes priority over a tick in the same clock.
- R5: `amp_word` is copied into the held amplitude only on a tick that wraps the index from 1023 to 0 with `cyc_start` low. At every other time, changes on `amp_word` leave all outputs unchanged.
- R6: Each output is registered. It changes on the clock edge after the edge at which the index or held amplitude changed, and holds its value while neither changes.
- R7: Channel p (0 = A in bits 15:0, 1 = B in bits 31:16, 2 = C in bits 47:32) reads table entry (index − offset_p) mod 1024, with offsets 0, 341 and 683. B thus lags A by 120° and C lags A by 240°.
- R8: Each channel is a 16-bit two's-complement value and reaches ±32385 at full amplitude (255) without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-clock strobe at 1024 × line frequency |
| cyc_start | input | 1 | One-clock strobe at the positive-going zero crossing |
| amp_word | input | 8 | Amplitude from the regulator, unsigned |
| ref_out | output | 48 | Three signed 16-bit references, channel A in the low bits |

## Verification
The hardest condition to reach is the amplitude hand-over. It happens only on the single tick that carries the index from 1023 to 0. Any other change on the amplitude input must have no visible effect. The stimulus drives a new amplitude word through 1023 ticks and checks that the outputs stay at zero. It then gives one more tick and checks that the word takes effect. Later vectors change the word mid-cycle and force an index reset with a cycle-start pulse, and both must leave the held amplitude alone.

// File: rtl/sref_pkg.sv
package sref_pkg;

  // Lag, in table entries, of channel p out of nph channels (rounded).
  function automatic int tap_offset(input int p, input int nph, input int depth);
    return (p * depth + nph / 2) / nph;
  endfunction

  // Offset-binary sine code for entry k of a depth-entry table of smp_w bits.
  function automatic int sine_code(input int k, input int depth, input int smp_w);
    real ang;
    real mag;
    int  mid;
    mid = 1 << (smp_w - 1);
    ang = 6.283185307179586 * real'(k) / real'(depth);
    mag = real'(mid - 1) * $sin(ang);
    return mid + int'(mag);
  endfunction

endpackage

// File: rtl/sref_phase_acc.sv
module sref_phase_acc #(
  parameter int IDX_W = 10,
  parameter int AMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [AMP_W-1:0] amp_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [AMP_W-1:0] amp_q, amp_d;
  logic             wrap;

  // Amplitude is taken only on the tick that closes a cycle.
  assign wrap = tick_i & ~sync_i & (idx_q == LAST_IDX);

  always_comb begin
    idx_d = idx_q;
    if (sync_i)
      idx_d = '0;
    else if (tick_i)
      idx_d = idx_q + IDX_W'(1);
  end

  always_comb begin
    amp_d = amp_q;
    if (wrap)
      amp_d = amp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      amp_q <= '0;
    end else begin
      idx_q <= idx_d;
      amp_q <= amp_d;
    end
  end

  assign idx_o = idx_q;
  assign amp_o = amp_q;

endmodule

// File: rtl/sref_sine_rom.sv
module sref_sine_rom #(
  parameter int IDX_W  = 10,
  parameter int SMP_W  = 8,
  parameter int NUM_RD = 3
) (
  input  logic [NUM_RD-1:0][IDX_W-1:0] addr_i,
  output logic [NUM_RD-1:0][SMP_W-1:0] code_o
);
  import sref_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [SMP_W-1:0] tbl [DEPTH];

  // Table contents are computed at elaboration, one entry per slot.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    assign tbl[gi] = SMP_W'(sine_code(gi, DEPTH, SMP_W));
  end

  for (genvar rp = 0; rp < NUM_RD; rp++) begin : g_port
    assign code_o[rp] = tbl[addr_i[rp]];
  end

endmodule

// File: rtl/sref_scale_reg.sv
module sref_scale_reg #(
  parameter int SMP_W = 8,
  parameter int AMP_W = 8,
  localparam int OUT_W = SMP_W + AMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] code_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic [OUT_W-1:0] ref_o
);

  logic [SMP_W-1:0]        smp;
  logic signed [OUT_W-1:0] smp_x, amp_x, prod;
  logic [OUT_W-1:0]        ref_q;

  // Offset binary to two's complement: invert the top bit.
  assign smp = code_i ^ {1'b1, {(SMP_W-1){1'b0}}};

  always_comb begin
    smp_x = $signed({{AMP_W{smp[SMP_W-1]}}, smp});
    amp_x = $signed({{SMP_W{1'b0}}, amp_i});
    prod  = smp_x * amp_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ref_q <= '0;
    else
      ref_q <= prod;
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/sref_gen.sv
module sref_gen #(
  parameter int NUM_PH = 3,
  parameter int IDX_W  = 10,
  parameter int SMP_W  = 8,
  parameter int AMP_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              line_tick,
  input  logic                              cyc_start,
  input  logic [AMP_W-1:0]                  amp_word,
  output logic [NUM_PH*(SMP_W+AMP_W)-1:0]   ref_out
);
  import sref_pkg::*;

  localparam int OUT_W = SMP_W + AMP_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0]                    rst_sync_q;
  logic                          rst_int_n;
  logic [IDX_W-1:0]              phase_idx;
  logic [AMP_W-1:0]              amp_q;
  logic [NUM_PH-1:0][IDX_W-1:0]  tap_addr;
  logic [NUM_PH-1:0][SMP_W-1:0]  tap_code;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sref_phase_acc #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_i (line_tick),
    .sync_i (cyc_start),
    .amp_i  (amp_word),
    .idx_o  (phase_idx),
    .amp_o  (amp_q)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_tap
    localparam logic [IDX_W-1:0] LAG = IDX_W'(tap_offset(p, NUM_PH, DEPTH));
    assign tap_addr[p] = phase_idx - LAG;
  end

  sref_sine_rom #(.IDX_W(IDX_W), .SMP_W(SMP_W), .NUM_RD(NUM_PH)) u_rom (
    .addr_i (tap_addr),
    .code_o (tap_code)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ch
    sref_scale_reg #(.SMP_W(SMP_W), .AMP_W(AMP_W)) u_scale (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .code_i (tap_code[p]),
      .amp_i  (amp_q),
      .ref_o  (ref_out[p*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/sref_gen_chk.sv
module sref_gen_chk #(
  parameter int IDX_W = 10,
  parameter int SMP_W = 8,
  parameter int AMP_W = 8,
  localparam int OUT_W = SMP_W + AMP_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             sync,
  input logic [AMP_W-1:0] amp_in,
  input logic [IDX_W-1:0] idx,
  input logic [AMP_W-1:0] amp_q,
  input logic [OUT_W-1:0] ref_a
);

  localparam logic [IDX_W-1:0] LAST_IDX = '1;
  localparam int FULL = ((1 << (SMP_W - 1)) - 1) * ((1 << AMP_W) - 1);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync) |=> idx == $past(idx) + IDX_W'(1));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sync) |=> $stable(idx));

  // R4
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> idx == '0);

  // R5
  amp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !sync && idx == LAST_IDX) |=> amp_q == $past(amp_in));

  // R5
  amp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && !sync && idx == LAST_IDX) |=> $stable(amp_q));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(idx) && $stable(amp_q)) |=> $stable(ref_a));

  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(ref_a) <= FULL) && ($signed(ref_a) >= -FULL));

endmodule

bind sref_gen sref_gen_chk #(.IDX_W(IDX_W), .SMP_W(SMP_W), .AMP_W(AMP_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_int_n),
  .tick   (line_tick),
  .sync   (cyc_start),
  .amp_in (amp_word),
  .idx    (phase_idx),
  .amp_q  (amp_q),
  .ref_a  (ref_out[OUT_W-1:0])
);

// File: tb/sref_gen_test.sv
module sref_gen_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_tick;
  logic        cyc_start;
  logic [7:0]  amp_word;
  logic [47:0] ref_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sref_gen uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .cyc_start (cyc_start),
    .amp_word  (amp_word),
    .ref_out   (ref_out)
  );

  typedef struct packed {
    logic       sync;
    logic [7:0] amp;
    logic [11:0] n;
    logic [9:0] eidx;
    logic [7:0] eamp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd200, 12'd1023, 10'd1023, 8'd0  },
    '{1'b0, 8'd200, 12'd1,    10'd0,    8'd200},
    '{1'b0, 8'd90,  12'd256,  10'd256,  8'd200},
    '{1'b0, 8'd90,  12'd256,  10'd512,  8'd200},
    '{1'b1, 8'd90,  12'd0,    10'd0,    8'd200},
    '{1'b0, 8'd90,  12'd768,  10'd768,  8'd200},
    '{1'b0, 8'd255, 12'd256,  10'd0,    8'd255},
    '{1'b0, 8'd255, 12'd256,  10'd256,  8'd255},
    '{1'b0, 8'd255, 12'd512,  10'd768,  8'd255}
  };

  function automatic int expect_ref(input int p, input int idx, input int amp);
    int lag [3] = '{0, 341, 683};
    int a;
    real s;
    a = ((idx - lag[p]) % 1024 + 1024) % 1024;
    s = $floor(127.0 * $sin(2.0 * 3.141592653589793 * real'(a) / 1024.0) + 0.5);
    return int'(s) * amp;
  endfunction

  function automatic int chan(input int p);
    return int'($signed(ref_out[p*16 +: 16]));
  endfunction

  task automatic check_val(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input int idx, input int amp);
    for (int p = 0; p < 3; p++)
      check_val($sformatf("%s ch%0d idx=%0d", tag, p, idx), chan(p), expect_ref(p, idx, amp));
  endtask

  task automatic tick_once();
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic sync_once();
    @(negedge clk) cyc_start = 1'b1;
    @(negedge clk) cyc_start = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    line_tick = 1'b0;
    cyc_start = 1'b0;
    amp_word = 8'd0;
    repeat (3) @(negedge clk);
    // R1: outputs zero while in reset
    check_all("R1 in reset", 0, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_all("R1 after release", 0, 0);

    // Vector walk: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      amp_word = VECS[v].amp;
      if (VECS[v].sync) sync_once();
      for (int t = 0; t < int'(VECS[v].n); t++) tick_once();
      check_all($sformatf("R2 R3 R4 R5 R7 R8 vec%0d", v), int'(VECS[v].eidx), int'(VECS[v].eamp));
    end

    // R8: full-scale extremes on channel A at amplitude 255
    check_val("R8 negative full scale", chan(0), -32385);

    // R6: output changes one clock after the index step, not at it
    @(negedge clk) line_tick = 1'b1;
    @(negedge clk) line_tick = 1'b0;
    check_all("R6 before update", 768, 255);
    @(negedge clk);
    check_all("R6 after update", 769, 255);

    // R3 R5 R6: no tick, amplitude input moving, outputs hold
    amp_word = 8'd17;
    repeat (10) @(negedge clk);
    check_all("R3 R5 R6 idle hold", 769, 255);

    // R4: cycle-start wins over a tick in the same clock; amplitude kept
    @(negedge clk) begin line_tick = 1'b1; cyc_start = 1'b1; end
    @(negedge clk) begin line_tick = 1'b0; cyc_start = 1'b0; end
    @(negedge clk);
    check_all("R4 sync over tick", 0, 255);
    tick_once();
    check_all("R4 count after sync", 1, 255);

    // R1: reset in mid-run clears index and amplitude
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid-run reset", 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tick_once();
    check_all("R1 amplitude cleared", 1, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule